// File: doc/BRIEF.md
# Serial Calibration Coefficient Register Bank

This block is a small register file that a host reaches over a bit-serial port. It holds a read-only 16-bit conversion result, an 8-bit test register, and one pair of 24-bit calibration coefficients (zero-scale and full-scale) for each input channel. Every access opens with a 4-bit command that names the target register and the transfer direction. A data phase follows whose length depends on the target. Bits travel most significant first in both directions.

The conversion datapath receives the zero-scale and full-scale coefficients of the active channel on dedicated outputs. It also receives a flag warning that the next result may be unreliable because the coefficients were touched over the host port. The datapath returns each finished conversion word to the bank, and that event clears the warning. Coefficient writes are guarded in two ways. A write that stops short of the full word changes nothing. A write that lands while a calibration is in progress is refused and raises a sticky error flag.

Top module: `cal_coef_bank`

## Requirements
- R1: An access starts when `frm` is high. Its first four `bit_stb` strobes carry the command, most significant bit first: bit 3 is the read flag (1 = read, 0 = write) and bits 2..0 are the select code. The data bits follow, also most significant first. Dropping `frm` at any point returns the port to the command phase.
- R2: The data phase length is set by the select code: 3'b011 takes 16 bits, 3'b100 takes 8 bits, and 3'b110 and 3'b111 take 24 bits. Every other code takes 8 bits, reads back as zero, and ignores written data.
- R3: Select 3'b011 reads the result register. That register loads `conv_data` on each `conv_done` pulse. A write to 3'b011 still clocks in all 16 bits, and the data is discarded.
- R4: Select 3'b100 is an 8-bit read/write test register that resets to 8'h00.
- R5: After reset, every channel's zero-scale coefficient (select 3'b110) is 24'h1F4000 and every full-scale coefficient (select 3'b111) is 24'h5761AB.
- R6: A coefficient write takes effect only when all 24 data bits have arrived. A frame dropped earlier leaves the register unchanged.
- R7: Each channel has its own coefficient pair. `ch_sel`, sampled when the command completes, picks the pair that a host access uses. `zs_coef` and `fs_coef` present the pair of channel `ch_sel`, one cycle behind.
- R8: A complete coefficient write that commits while `cal_busy` is high is refused: the stored value is kept and `wr_err` goes high, staying high until reset.
- R9: `res_bad` goes high one cycle after a command addressing a coefficient register (read or write) completes while `sync_hold` is low. It returns low on the cycle after the next `conv_done`. If both happen in the same cycle, setting wins. With `sync_hold` high, the access leaves `res_bad` unchanged.
- R10: `sdo` is low outside the data phase of a read. During that data phase it shows the next bit to be read, starting with the most significant bit right after the command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm | input | 1 | Frame enable of the serial port; low aborts an access |
| bit_stb | input | 1 | One-cycle strobe marking a serial bit |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| ch_sel | input | 1 | Active channel index |
| sync_hold | input | 1 | Hold flag; when high, coefficient access does not taint the result |
| cal_busy | input | 1 | Calibration in progress |
| conv_done | input | 1 | Conversion completed pulse |
| conv_data | input | 16 | Completed conversion result |
| zs_coef | output | 24 | Zero-scale coefficient of the active channel |
| fs_coef | output | 24 | Full-scale coefficient of the active channel |
| res_bad | output | 1 | Next conversion result is untrustworthy |
| wr_err | output | 1 | Sticky flag for a refused coefficient write |

## Verification
The assertions assume that `bit_stb` is only pulsed while `frm` is high. They also assume that `ch_sel`, `cal_busy` and `sync_hold` stay steady for the whole of an access. The stimulus sets these inputs between frames and holds them until the access and its commit cycle are over. Frames are always separated by idle cycles with `frm` low, and strobes are one cycle wide with a gap between them. Aborts happen only during a write's data phase, so every abort follows a completed command.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
  localparam int unsigned COEF_W = 24;
  localparam int unsigned RES_W  = 16;
  localparam int unsigned TEST_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned CMD_W  = SEL_W + 1;
  localparam int unsigned LEN_W  = $clog2(COEF_W + 1);

  localparam logic [SEL_W-1:0] SEL_RES  = 3'b011;
  localparam logic [SEL_W-1:0] SEL_TEST = 3'b100;
  localparam logic [SEL_W-1:0] SEL_ZS   = 3'b110;
  localparam logic [SEL_W-1:0] SEL_FS   = 3'b111;

  localparam logic [COEF_W-1:0] ZS_INIT = 24'h1F4000;
  localparam logic [COEF_W-1:0] FS_INIT = 24'h5761AB;

  function automatic logic [LEN_W-1:0] word_len(input logic [SEL_W-1:0] sel);
    case (sel)
      SEL_RES:        word_len = LEN_W'(RES_W);
      SEL_ZS, SEL_FS: word_len = LEN_W'(COEF_W);
      default:        word_len = LEN_W'(TEST_W);
    endcase
  endfunction

  function automatic logic is_coef(input logic [SEL_W-1:0] sel);
    is_coef = (sel == SEL_ZS) || (sel == SEL_FS);
  endfunction
endpackage

// File: rtl/cbk_serial_port.sv
module cbk_serial_port
  import cbk_pkg::*;
#(
  parameter int unsigned SH_W  = COEF_W,
  localparam int unsigned CNT_W = $clog2(SH_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm,
  input  logic              bit_stb,
  input  logic              sdi,
  output logic              sdo,
  input  logic [SH_W-1:0]   rd_word,
  output logic              cmd_hit,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic              wr_stb,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [SH_W-1:0]   wr_word
);
  logic              in_data_q, rd_q, wr_stb_q;
  logic [SEL_W-1:0]  cmd_sh_q, sel_q, wr_sel_q;
  logic [CNT_W-1:0]  cnt_q, len_q, len_n;
  logic [SH_W-1:0]   sh_q, wr_word_q;
  logic [CMD_W-1:0]  cmd_n;
  logic              step, last_bit;

  assign step     = frm & bit_stb;
  assign cmd_n    = {cmd_sh_q, sdi};
  assign len_n    = CNT_W'(word_len(cmd_n[SEL_W-1:0]));
  assign cmd_hit  = step & ~in_data_q & (cnt_q == CNT_W'(CMD_W - 1));
  assign cmd_sel  = cmd_n[SEL_W-1:0];
  assign last_bit = step & in_data_q & (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_data_q <= 1'b0;
      rd_q      <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      cmd_sh_q  <= '0;
      sel_q     <= '0;
      sh_q      <= '0;
      wr_stb_q  <= 1'b0;
      wr_sel_q  <= '0;
      wr_word_q <= '0;
    end else if (!frm) begin
      in_data_q <= 1'b0;
      cnt_q     <= '0;
      wr_stb_q  <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      if (step) begin
        if (!in_data_q) begin
          cmd_sh_q <= cmd_n[SEL_W-1:0];
          if (cmd_hit) begin
            in_data_q <= 1'b1;
            cnt_q     <= '0;
            rd_q      <= cmd_n[CMD_W-1];
            sel_q     <= cmd_n[SEL_W-1:0];
            len_q     <= len_n;
            sh_q      <= cmd_n[CMD_W-1] ? (rd_word << (CNT_W'(SH_W) - len_n)) : '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else begin
          sh_q <= {sh_q[SH_W-2:0], sdi};
          if (last_bit) begin
            in_data_q <= 1'b0;
            cnt_q     <= '0;
            wr_stb_q  <= ~rd_q;
            wr_sel_q  <= sel_q;
            wr_word_q <= {sh_q[SH_W-2:0], sdi};
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign sdo     = in_data_q & rd_q & sh_q[SH_W-1];
  assign wr_stb  = wr_stb_q;
  assign wr_sel  = wr_sel_q;
  assign wr_word = wr_word_q;

  a_r1_abort_idle: assert property (@(posedge clk) disable iff (rst)
    !frm |=> (!in_data_q && cnt_q == '0));
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    in_data_q |-> (cnt_q < len_q));
  a_r10_sdo_quiet: assert property (@(posedge clk) disable iff (rst)
    !frm |=> !sdo);
  a_r6_commit_whole: assert property (@(posedge clk) disable iff (rst)
    wr_stb_q |-> ($past(in_data_q) && !in_data_q));
endmodule

// File: rtl/cbk_coef_store.sv
module cbk_coef_store
  import cbk_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned W   = COEF_W,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_W-1:0] act_ch,
  input  logic [CH_W-1:0] wr_ch,
  input  logic            we_zs,
  input  logic            we_fs,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rd_zs,
  output logic [W-1:0]    rd_fs,
  output logic [W-1:0]    zs_act,
  output logic [W-1:0]    fs_act
);
  logic [W-1:0] zs_mem [NCH];
  logic [W-1:0] fs_mem [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        zs_mem[i] <= W'(ZS_INIT);
        fs_mem[i] <= W'(FS_INIT);
      end else begin
        if (we_zs && wr_ch == CH_W'(i)) zs_mem[i] <= wdata;
        if (we_fs && wr_ch == CH_W'(i)) fs_mem[i] <= wdata;
      end
    end

    a_r6_zs_hold: assert property (@(posedge clk) disable iff (rst)
      !(we_zs && wr_ch == CH_W'(i)) |=> $stable(zs_mem[i]));
    a_r6_fs_hold: assert property (@(posedge clk) disable iff (rst)
      !(we_fs && wr_ch == CH_W'(i)) |=> $stable(fs_mem[i]));
  end

  assign rd_zs = zs_mem[act_ch];
  assign rd_fs = fs_mem[act_ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      zs_act <= W'(ZS_INIT);
      fs_act <= W'(FS_INIT);
    end else begin
      zs_act <= zs_mem[act_ch];
      fs_act <= fs_mem[act_ch];
    end
  end
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
  import cbk_pkg::*;
#(
  parameter int unsigned NCH = 2,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm,
  input  logic              bit_stb,
  input  logic              sdi,
  output logic              sdo,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic              sync_hold,
  input  logic              cal_busy,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic [COEF_W-1:0] zs_coef,
  output logic [COEF_W-1:0] fs_coef,
  output logic              res_bad,
  output logic              wr_err
);
  logic              cmd_hit, wr_stb;
  logic [SEL_W-1:0]  cmd_sel, wr_sel;
  logic [COEF_W-1:0] rd_word, wr_word, rd_zs, rd_fs;
  logic [RES_W-1:0]  res_q;
  logic [TEST_W-1:0] test_q;
  logic [CH_W-1:0]   acc_ch_q;
  logic              bad_q, err_q;
  logic              coef_cmd, wr_coef, we_zs, we_fs;

  cbk_serial_port #(.SH_W(COEF_W)) port_i (
    .clk(clk), .rst(rst), .frm(frm), .bit_stb(bit_stb), .sdi(sdi), .sdo(sdo),
    .rd_word(rd_word), .cmd_hit(cmd_hit), .cmd_sel(cmd_sel),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_word(wr_word)
  );

  cbk_coef_store #(.NCH(NCH), .W(COEF_W)) store_i (
    .clk(clk), .rst(rst), .act_ch(ch_sel), .wr_ch(acc_ch_q),
    .we_zs(we_zs), .we_fs(we_fs), .wdata(wr_word),
    .rd_zs(rd_zs), .rd_fs(rd_fs), .zs_act(zs_coef), .fs_act(fs_coef)
  );

  always_comb begin
    case (cmd_sel)
      SEL_RES:  rd_word = COEF_W'(res_q);
      SEL_TEST: rd_word = COEF_W'(test_q);
      SEL_ZS:   rd_word = rd_zs;
      SEL_FS:   rd_word = rd_fs;
      default:  rd_word = '0;
    endcase
  end

  assign coef_cmd = cmd_hit & is_coef(cmd_sel);
  assign wr_coef  = wr_stb & is_coef(wr_sel);
  assign we_zs    = wr_coef & ~cal_busy & (wr_sel == SEL_ZS);
  assign we_fs    = wr_coef & ~cal_busy & (wr_sel == SEL_FS);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q    <= '0;
      test_q   <= '0;
      acc_ch_q <= '0;
      bad_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (conv_done) res_q <= conv_data;
      if (wr_stb && wr_sel == SEL_TEST) test_q <= wr_word[TEST_W-1:0];
      if (cmd_hit) acc_ch_q <= ch_sel;
      if (coef_cmd && !sync_hold) bad_q <= 1'b1;
      else if (conv_done)         bad_q <= 1'b0;
      if (wr_coef && cal_busy) err_q <= 1'b1;
    end
  end

  assign res_bad = bad_q;
  assign wr_err  = err_q;

  a_r3_result_discard: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_sel == SEL_RES && !conv_done) |=> $stable(res_q));
  a_r8_reject_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_coef && cal_busy) |=> wr_err);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);
  a_r9_taint_set: assert property (@(posedge clk) disable iff (rst)
    (coef_cmd && !sync_hold) |=> res_bad);
  a_r9_taint_clear: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !coef_cmd) |=> !res_bad);
endmodule

// File: tb/cal_coef_bank_tb_top.sv
module cal_coef_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm = 1'b0, bit_stb = 1'b0, sdi = 1'b0;
  logic        sdo;
  logic [0:0]  ch_sel = 1'b0;
  logic        sync_hold = 1'b0, cal_busy = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic [23:0] zs_coef, fs_coef;
  logic        res_bad, wr_err;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [23:0] zs_m [2];
  logic [23:0] fs_m [2];
  logic [7:0]  test_m;
  logic [15:0] res_m;
  logic        bad_m, err_m;

  always #2.5 clk = ~clk;

  cal_coef_bank dut_i (
    .clk(clk), .rst(rst), .frm(frm), .bit_stb(bit_stb), .sdi(sdi), .sdo(sdo),
    .ch_sel(ch_sel), .sync_hold(sync_hold), .cal_busy(cal_busy),
    .conv_done(conv_done), .conv_data(conv_data),
    .zs_coef(zs_coef), .fs_coef(fs_coef), .res_bad(res_bad), .wr_err(wr_err)
  );

  function automatic int len_of(input logic [2:0] s);
    if (s == 3'b011) return 16;
    if (s == 3'b110 || s == 3'b111) return 24;
    return 8;
  endfunction

  function automatic logic [23:0] model_rd(input logic [2:0] s, input logic c);
    case (s)
      3'b011:  return {8'h00, res_m};
      3'b100:  return {16'h0000, test_m};
      3'b110:  return zs_m[c];
      3'b111:  return fs_m[c];
      default: return 24'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_bit(input logic b);
    @(negedge clk); sdi = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  // abort_at < 0: no abort; otherwise frm drops before data bit abort_at
  task automatic access(input logic rd, input logic [2:0] sel, input logic [23:0] wdat,
                        input int abort_at, output logic [23:0] rdat);
    int len;
    len = len_of(sel);
    rdat = '0;
    @(negedge clk); frm = 1'b1;
    pulse_bit(rd);
    for (int i = 2; i >= 0; i--) pulse_bit(sel[i]);
    if (sel[2:1] == 2'b11 && !sync_hold) bad_m = 1'b1;
    for (int i = len - 1; i >= 0; i--) begin
      if (abort_at == len - 1 - i) break;
      @(negedge clk);
      rdat[i] = sdo;
      sdi = wdat[i]; bit_stb = 1'b1;
      @(negedge clk); bit_stb = 1'b0;
    end
    @(negedge clk); frm = 1'b0;
    repeat (3) @(negedge clk);
    if (!rd && abort_at < 0) begin
      if (sel[2:1] == 2'b11 && cal_busy) err_m = 1'b1;
      else if (sel == 3'b110) zs_m[ch_sel] = wdat;
      else if (sel == 3'b111) fs_m[ch_sel] = wdat;
      else if (sel == 3'b100) test_m = wdat[7:0];
    end
  endtask

  task automatic convert(input logic [15:0] d);
    @(negedge clk); conv_data = d; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    res_m = d; bad_m = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_outs(input string tag);
    check({tag, " R7 zs_coef"}, zs_coef, zs_m[ch_sel]);
    check({tag, " R7 fs_coef"}, fs_coef, fs_m[ch_sel]);
    check({tag, " R9 res_bad"}, {23'h0, res_bad}, {23'h0, bad_m});
    check({tag, " R8 wr_err"}, {23'h0, wr_err}, {23'h0, err_m});
    check({tag, " R10 sdo idle"}, {23'h0, sdo}, 24'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [23:0] r, w;
    logic [2:0]  s;
    int k;
    void'($urandom(32'd2718));
    zs_m[0] = 24'h1F4000; zs_m[1] = 24'h1F4000;
    fs_m[0] = 24'h5761AB; fs_m[1] = 24'h5761AB;
    test_m = 8'h00; res_m = 16'h0; bad_m = 1'b0; err_m = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R5, R8, R9, R10)
    check_outs("reset R5");

    access(1'b1, 3'b100, 24'h0, -1, r); check("R4 test reset", r, 24'h0);
    ch_sel = 1'b1; sync_hold = 1'b1;
    access(1'b1, 3'b110, 24'h0, -1, r); check("R5 zs ch1 reset", r, 24'h1F4000);
    access(1'b1, 3'b111, 24'h0, -1, r); check("R5 fs ch1 reset", r, 24'h5761AB);
    check_outs("R9 hold no taint");

    // R1 R6 R7: full write to ch1, ch0 untouched
    access(1'b0, 3'b110, 24'hA5C3E1, -1, r);
    access(1'b1, 3'b110, 24'h0, -1, r); check("R1 R7 zs ch1 readback", r, 24'hA5C3E1);
    check_outs("R7 ch1");
    ch_sel = 1'b0; @(negedge clk); @(negedge clk);
    access(1'b1, 3'b110, 24'h0, -1, r); check("R7 zs ch0 untouched", r, 24'h1F4000);
    check_outs("R7 ch0");

    // R6: aborted coefficient write
    access(1'b0, 3'b111, 24'h123456, 12, r);
    access(1'b1, 3'b111, 24'h0, -1, r); check("R6 abort keeps fs", r, 24'h5761AB);
    access(1'b0, 3'b111, 24'h654321, 23, r);
    access(1'b1, 3'b111, 24'h0, -1, r); check("R6 abort at last bit", r, 24'h5761AB);

    // R3: result write discarded, conversion loads
    convert(16'hBEEF);
    access(1'b0, 3'b011, 24'h00_1234, -1, r);
    access(1'b1, 3'b011, 24'h0, -1, r); check("R3 result write discarded", r, 24'h00BEEF);

    // R4 test register write
    access(1'b0, 3'b100, 24'h00005A, -1, r);
    access(1'b1, 3'b100, 24'h0, -1, r); check("R4 test readback", r, 24'h00005A);

    // R2: unassigned code reads zero, write ignored
    access(1'b0, 3'b001, 24'h0000FF, -1, r);
    access(1'b1, 3'b001, 24'h0, -1, r); check("R2 unassigned read", r, 24'h0);
    access(1'b1, 3'b100, 24'h0, -1, r); check("R2 test intact", r, 24'h00005A);

    // R8: refused write during calibration
    cal_busy = 1'b1;
    access(1'b0, 3'b110, 24'h777777, -1, r);
    cal_busy = 1'b0;
    access(1'b1, 3'b110, 24'h0, -1, r); check("R8 refused write", r, 24'h1F4000);
    check_outs("R8 flag");

    // R9: taint and clear
    sync_hold = 1'b0;
    access(1'b1, 3'b111, 24'h0, -1, r);
    check("R9 taint set", {23'h0, res_bad}, 24'h1);
    convert(16'h0042);
    check("R9 taint cleared", {23'h0, res_bad}, 24'h0);

    // random mix
    for (int it = 0; it < 220; it++) begin
      ch_sel = 1'($urandom_range(0, 1));
      sync_hold = 1'($urandom_range(0, 1));
      @(negedge clk); @(negedge clk);
      k = $urandom_range(0, 9);
      s = 3'($urandom_range(0, 7));
      w = 24'($urandom);
      if (k < 2) begin
        convert(16'($urandom));
      end else if (k < 6) begin
        access(1'b1, s, 24'h0, -1, r);
        check($sformatf("R1 R2 rand read sel=%b", s), r, model_rd(s, ch_sel));
      end else if (k < 8) begin
        access(1'b0, s, w & ((24'h1 << len_of(s)) - 24'h1), -1, r);
      end else if (k == 8) begin
        cal_busy = 1'b1;
        access(1'b0, s, w & ((24'h1 << len_of(s)) - 24'h1), -1, r);
        cal_busy = 1'b0;
      end else begin
        access(1'b0, s, w, $urandom_range(0, len_of(s) - 1), r);
      end
      check_outs($sformatf("rand %0d", it));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule